// File: doc/BRIEF.md
# Quad Byte Multiply Execution Unit

This block is a single-cycle SIMD execution stage for a media coprocessor. From the instruction word it extracts two source register indices, two destination register indices and a two-bit selector. It splits two 32-bit operands into four byte lanes. It multiplies each lane pair in parallel and keeps the low 16 bits of every product. It then packs the four products into two 32-bit results, each with its own destination index and write strobe.

The source indices are decoded combinationally, so the surrounding register file can read the two operands in the same cycle. The instruction port carries only bits 23 down to 6 of the instruction word, numbered as in the full word; the bits outside this range play no part here. One selector value makes the first operand's bytes signed. The second operand's bytes are always unsigned. The result is registered and appears one cycle after the accepted input. Nothing is written while the coprocessor enable bit is clear.

Top module: `quad_byte_mul`

## Requirements
- R1: Instruction fields decode from fixed positions of the instruction word: destination A index from bits [9:6], source B index from bits [13:10], source C index from bits [17:14], destination D index from bits [21:18], selector from bits [23:22]. The source indices appear combinationally on `src_b_idx` and `src_c_idx`.
- R2: When the selector equals 2'b10, every byte of operand B is sign-extended before its multiply. For selectors 2'b00, 2'b01 and 2'b11, the bytes of B are zero-extended.
- R3: The bytes of operand C are zero-extended under every selector value. The signed mode is therefore signed-by-unsigned (for example, B byte 0xFF times C byte 0x80 gives 0xFF80).
- R4: Lane i multiplies byte i of B by byte i of C, where byte 0 is bits [7:0], and only the low 16 bits of each product are kept (for example, signed 0x80 times 0xFF gives 0x8080, and 0x7F times 0xFF gives 0x7E81).
- R5: Result D holds the lane 1 product in bits [31:16] and the lane 0 product in bits [15:0]. Result A holds the lane 3 product in bits [31:16] and the lane 2 product in bits [15:0].
- R6: No write strobe rises unless both `valid_i` and `cop_en_i` are high in the accepted cycle.
- R7: When the destination A and D indices are equal, only the A write is issued (`wa_en`=1, `wd_en`=0).
- R8: The outputs update on the clock edge that samples a valid input and stay active for exactly one cycle per accepted input.
- R9: A synchronous active-high reset clears both write strobes, whatever the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Instruction present this cycle |
| cop_en_i | input | 1 | Coprocessor global enable bit |
| insn_i | input | 18 | Instruction word bits [23:6], indexed 23..6 |
| opb_i | input | 32 | Source B operand value |
| opc_i | input | 32 | Source C operand value |
| src_b_idx | output | 4 | Decoded source B register index |
| src_c_idx | output | 4 | Decoded source C register index |
| wa_en | output | 1 | Write strobe for destination A |
| wa_idx | output | 4 | Destination A register index |
| wa_data | output | 32 | Packed lanes 3 and 2 |
| wd_en | output | 1 | Write strobe for destination D |
| wd_idx | output | 4 | Destination D register index |
| wd_data | output | 32 | Packed lanes 1 and 0 |

## Verification
A fault in one lane's extension or multiply corrupts one 16-bit half of one result. That error is visible on the very next cycle after the input is accepted. The signed corners 0x80 and 0x7F against 0xFF, and a negative B byte against a C byte with its top bit set, each separate sign handling from zero handling on a single operation. A fault in the strobe register shows up as a write that appears with the enable cleared, or that persists past its one cycle, or that is missing. A missing write is visible on the cycle it should have happened; a persisting write is visible one cycle later.

// File: rtl/qbm_pkg.sv
package qbm_pkg;

    localparam int QBM_LANES  = 4;
    localparam int QBM_BYTE_W = 8;
    localparam int QBM_IDX_W  = 4;
    localparam int QBM_SEL_W  = 2;

    // Field least-significant bit positions within the instruction word
    localparam int QBM_DA_LSB  = 6;
    localparam int QBM_SB_LSB  = 10;
    localparam int QBM_SC_LSB  = 14;
    localparam int QBM_DD_LSB  = 18;
    localparam int QBM_SEL_LSB = 22;
    localparam int QBM_FLD_HI  = QBM_SEL_LSB + QBM_SEL_W - 1;

    localparam logic [QBM_SEL_W-1:0] QBM_SEL_SIGNED = 2'b10;

    typedef enum logic {
        EXT_ZERO = 1'b0,
        EXT_SIGN = 1'b1
    } qbm_ext_e;

    typedef struct packed {
        logic [QBM_IDX_W-1:0] dst_a;
        logic [QBM_IDX_W-1:0] src_b;
        logic [QBM_IDX_W-1:0] src_c;
        logic [QBM_IDX_W-1:0] dst_d;
        qbm_ext_e             b_ext;
    } qbm_fields_t;

endpackage

// File: rtl/qbm_decode.sv
module qbm_decode
    import qbm_pkg::*;
(
    input  logic [QBM_FLD_HI:QBM_DA_LSB] insn_i,
    output qbm_fields_t                   fields_o
);

    logic [QBM_SEL_W-1:0] sel;

    always_comb begin
        sel             = insn_i[QBM_SEL_LSB +: QBM_SEL_W];
        fields_o.dst_a  = insn_i[QBM_DA_LSB +: QBM_IDX_W];
        fields_o.src_b  = insn_i[QBM_SB_LSB +: QBM_IDX_W];
        fields_o.src_c  = insn_i[QBM_SC_LSB +: QBM_IDX_W];
        fields_o.dst_d  = insn_i[QBM_DD_LSB +: QBM_IDX_W];
        fields_o.b_ext  = (sel == QBM_SEL_SIGNED) ? EXT_SIGN : EXT_ZERO;
    end

endmodule

// File: rtl/qbm_lane.sv
module qbm_lane
    import qbm_pkg::*;
#(
    parameter int BYTE_W = QBM_BYTE_W
) (
    input  logic [BYTE_W-1:0]   b_byte,
    input  logic [BYTE_W-1:0]   c_byte,
    input  qbm_ext_e            b_ext,
    output logic [2*BYTE_W-1:0] prod
);

    localparam int EXT_W  = BYTE_W + 1;
    localparam int PROD_W = 2 * BYTE_W;

    logic signed [EXT_W-1:0]  b_wide;
    logic signed [EXT_W-1:0]  c_wide;
    logic signed [PROD_W-1:0] prod_s;

    // B takes its top bit only in signed mode; C never does
    assign b_wide = {(b_ext == EXT_SIGN) & b_byte[BYTE_W-1], b_byte};
    assign c_wide = {1'b0, c_byte};
    // Modular product: the low PROD_W bits are all that are kept
    assign prod_s = PROD_W'(b_wide) * PROD_W'(c_wide);
    assign prod   = $unsigned(prod_s);

endmodule

// File: rtl/qbm_pack.sv
module qbm_pack
    import qbm_pkg::*;
#(
    parameter int LANES  = QBM_LANES,
    parameter int BYTE_W = QBM_BYTE_W,
    parameter int IDX_W  = QBM_IDX_W
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 fire,
    input  logic [IDX_W-1:0]                     dst_a,
    input  logic [IDX_W-1:0]                     dst_d,
    input  logic [LANES-1:0][2*BYTE_W-1:0]       prods,
    output logic                                 wa_en,
    output logic [IDX_W-1:0]                     wa_idx,
    output logic [LANES*BYTE_W-1:0]              wa_data,
    output logic                                 wd_en,
    output logic [IDX_W-1:0]                     wd_idx,
    output logic [LANES*BYTE_W-1:0]              wd_data
);

    localparam int HALF   = LANES / 2;
    localparam int WORD_W = LANES * BYTE_W;

    logic [WORD_W-1:0] lo_word;
    logic [WORD_W-1:0] hi_word;
    logic              clash;

    assign lo_word = prods[HALF-1:0];
    assign hi_word = prods[LANES-1:HALF];
    assign clash   = (dst_a == dst_d);

    always_ff @(posedge clk) begin
        if (rst) begin
            wa_en   <= 1'b0;
            wd_en   <= 1'b0;
            wa_idx  <= '0;
            wd_idx  <= '0;
            wa_data <= '0;
            wd_data <= '0;
        end else begin
            wa_en <= fire;
            wd_en <= fire && !clash;
            if (fire) begin
                wa_idx  <= dst_a;
                wd_idx  <= dst_d;
                wa_data <= hi_word;
                wd_data <= lo_word;
            end
        end
    end

    // R7
    same_dest_single_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wa_en && wd_en) |-> (wa_idx != wd_idx));

    // R7
    a_wins_on_clash_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && clash) |=> (wa_en && !wd_en));

    // R6
    strobe_needs_fire_chk: assert property (@(posedge clk) disable iff (rst)
        (wa_en || wd_en) |-> $past(fire));

    // R8
    one_cycle_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !fire |=> !wa_en && !wd_en);

    // R9
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> !wa_en && !wd_en);

endmodule

// File: rtl/quad_byte_mul.sv
module quad_byte_mul
    import qbm_pkg::*;
#(
    parameter int LANES  = QBM_LANES,
    parameter int BYTE_W = QBM_BYTE_W,
    parameter int IDX_W  = QBM_IDX_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         valid_i,
    input  logic                         cop_en_i,
    input  logic [QBM_FLD_HI:QBM_DA_LSB] insn_i,
    input  logic [LANES*BYTE_W-1:0]      opb_i,
    input  logic [LANES*BYTE_W-1:0]      opc_i,
    output logic [IDX_W-1:0]             src_b_idx,
    output logic [IDX_W-1:0]             src_c_idx,
    output logic                         wa_en,
    output logic [IDX_W-1:0]             wa_idx,
    output logic [LANES*BYTE_W-1:0]      wa_data,
    output logic                         wd_en,
    output logic [IDX_W-1:0]             wd_idx,
    output logic [LANES*BYTE_W-1:0]      wd_data
);

    localparam int PROD_W = 2 * BYTE_W;

    qbm_fields_t                   fld;
    logic [LANES-1:0][PROD_W-1:0]  prods;
    logic                          fire;

    qbm_decode u_decode (
        .insn_i   (insn_i),
        .fields_o (fld)
    );

    assign src_b_idx = fld.src_b;
    assign src_c_idx = fld.src_c;
    assign fire      = valid_i && cop_en_i;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        qbm_lane #(.BYTE_W(BYTE_W)) u_lane (
            .b_byte (opb_i[i*BYTE_W +: BYTE_W]),
            .c_byte (opc_i[i*BYTE_W +: BYTE_W]),
            .b_ext  (fld.b_ext),
            .prod   (prods[i])
        );
    end

    qbm_pack #(.LANES(LANES), .BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_pack (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire),
        .dst_a   (fld.dst_a),
        .dst_d   (fld.dst_d),
        .prods   (prods),
        .wa_en   (wa_en),
        .wa_idx  (wa_idx),
        .wa_data (wa_data),
        .wd_en   (wd_en),
        .wd_idx  (wd_idx),
        .wd_data (wd_data)
    );

    // R1
    src_idx_decode_chk: assert property (@(posedge clk) disable iff (rst)
        (src_b_idx == insn_i[13:10]) && (src_c_idx == insn_i[17:14]));

    // R6
    no_write_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !cop_en_i |=> !wa_en && !wd_en);

endmodule

// File: tb/quad_byte_mul_tb.sv
`timescale 1ns/1ps
module quad_byte_mul_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic        cop_en_i = 1'b0;
    logic [23:6] insn_i = '0;
    logic [31:0] opb_i = '0;
    logic [31:0] opc_i = '0;
    logic [3:0]  src_b_idx, src_c_idx, wa_idx, wd_idx;
    logic        wa_en, wd_en;
    logic [31:0] wa_data, wd_data;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    quad_byte_mul u_dut (
        .clk(clk), .rst(rst), .valid_i(valid_i), .cop_en_i(cop_en_i),
        .insn_i(insn_i), .opb_i(opb_i), .opc_i(opc_i),
        .src_b_idx(src_b_idx), .src_c_idx(src_c_idx),
        .wa_en(wa_en), .wa_idx(wa_idx), .wa_data(wa_data),
        .wd_en(wd_en), .wd_idx(wd_idx), .wd_data(wd_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_lane(input logic [7:0] b, input logic [7:0] c,
                                             input bit sgn);
        int bv;
        int cv;
        bv = sgn ? int'($signed(b)) : int'(b);
        cv = int'(c);
        return 16'(bv * cv);
    endfunction

    function automatic logic [31:0] ref_word(input logic [31:0] b, input logic [31:0] c,
                                             input bit sgn, input int hi_lane);
        return {ref_lane(b[hi_lane*8 +: 8], c[hi_lane*8 +: 8], sgn),
                ref_lane(b[(hi_lane-1)*8 +: 8], c[(hi_lane-1)*8 +: 8], sgn)};
    endfunction

    // One accepted (or refused) instruction, checked one cycle later
    task automatic run_op(input logic [3:0] da, input logic [3:0] sb, input logic [3:0] sc,
                          input logic [3:0] dd, input logic [1:0] sel,
                          input logic [31:0] b, input logic [31:0] c,
                          input bit v, input bit en, input string tag);
        bit sgn;
        bit exp_a;
        bit exp_d;
        logic [31:0] ea;
        logic [31:0] ed;
        sgn   = (sel == 2'b10);
        exp_a = v && en;
        exp_d = v && en && (da != dd);
        ea    = ref_word(b, c, sgn, 3);
        ed    = ref_word(b, c, sgn, 1);
        @(negedge clk);
        insn_i   = {sel, dd, sc, sb, da};
        opb_i    = b;
        opc_i    = c;
        valid_i  = v;
        cop_en_i = en;
        #1;
        chk(src_b_idx == sb, "R1 src_b", {28'b0, src_b_idx}, {28'b0, sb});
        chk(src_c_idx == sc, "R1 src_c", {28'b0, src_c_idx}, {28'b0, sc});
        @(negedge clk);
        chk(wa_en == exp_a, {tag, " R6/R8 wa_en"}, {31'b0, wa_en}, {31'b0, exp_a});
        chk(wd_en == exp_d, {tag, " R6/R7 wd_en"}, {31'b0, wd_en}, {31'b0, exp_d});
        if (exp_a) begin
            chk(wa_idx == da, {tag, " R1 wa_idx"}, {28'b0, wa_idx}, {28'b0, da});
            chk(wa_data == ea, {tag, " R4/R5 wa_data"}, wa_data, ea);
        end
        if (exp_d) begin
            chk(wd_idx == dd, {tag, " R1 wd_idx"}, {28'b0, wd_idx}, {28'b0, dd});
            chk(wd_data == ed, {tag, " R4/R5 wd_data"}, wd_data, ed);
        end
        valid_i = 1'b0;
        @(negedge clk);
        chk(!wa_en && !wd_en, {tag, " R8 single cycle"}, {30'b0, wa_en, wd_en}, 32'h0);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        // R9: reset holds strobes low even with a valid enabled input
        valid_i  = 1'b1;
        cop_en_i = 1'b1;
        repeat (3) @(negedge clk);
        chk(!wa_en && !wd_en, "R9 reset strobes", {30'b0, wa_en, wd_en}, 32'h0);
        valid_i = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        chk(!wa_en && !wd_en, "R9 after reset", {30'b0, wa_en, wd_en}, 32'h0);

        // R2/R4: signed corners 0x80*0xFF=0x8080, 0x7F*0xFF=0x7E81
        run_op(4'd1, 4'd2, 4'd3, 4'd4, 2'b10, 32'h7F80_7F80, 32'hFFFF_FFFF, 1, 1, "R2 signed corner");
        chk(wd_data == 32'h7E81_8080, "R4 signed corner literal", wd_data, 32'h7E81_8080);
        // R2: unsigned under the other selectors
        run_op(4'd5, 4'd6, 4'd7, 4'd8, 2'b00, 32'h7F80_7F80, 32'hFFFF_FFFF, 1, 1, "R2 sel00");
        chk(wd_data == 32'h7E81_7F80, "R2 unsigned literal", wd_data, 32'h7E81_7F80);
        run_op(4'd9, 4'd1, 4'd2, 4'd3, 2'b01, 32'h80FF_0102, 32'hFF80_FEFD, 1, 1, "R2 sel01");
        run_op(4'd9, 4'd1, 4'd2, 4'd3, 2'b11, 32'h80FF_0102, 32'hFF80_FEFD, 1, 1, "R2 sel11");
        // R3: C byte 0x80 stays +128 -> 0xFF * 0x80 signed-B = 0xFF80
        run_op(4'd2, 4'd0, 4'd0, 4'd3, 2'b10, 32'h0000_00FF, 32'h0000_0080, 1, 1, "R3 zero-ext C");
        chk(wd_data[15:0] == 16'hFF80, "R3 literal", {16'b0, wd_data[15:0]}, 32'h0000_FF80);
        // R5: distinct lane values show placement
        run_op(4'd10, 4'd0, 4'd0, 4'd11, 2'b00, 32'h0403_0201, 32'h0101_0101, 1, 1, "R5 packing");
        chk(wa_data == 32'h0004_0003 && wd_data == 32'h0002_0001, "R5 literal", wa_data, 32'h0004_0003);
        // R6: enable clear and valid low
        run_op(4'd1, 4'd2, 4'd3, 4'd4, 2'b10, 32'h1234_5678, 32'h9ABC_DEF0, 1, 0, "R6 enable off");
        run_op(4'd1, 4'd2, 4'd3, 4'd4, 2'b00, 32'h1234_5678, 32'h9ABC_DEF0, 0, 1, "R6 valid low");
        // R7: same destination
        run_op(4'd6, 4'd2, 4'd3, 4'd6, 2'b10, 32'hDEAD_BEEF, 32'hCAFE_F00D, 1, 1, "R7 clash");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom();
            run_op(r[3:0], r[7:4], r[11:8], (r[12] ? r[3:0] : r[16:13]), r[18:17],
                   $urandom(), $urandom(), (r[21:19] != 0), (r[24:22] != 0), "random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule